// File: doc/BRIEF.md
# Capture/Compare Channel Polarity Stage

This block conditions the pin side of two timer capture/compare channels. Each channel can work as an input or as an output, and a per-channel mode input chooses which. In input mode the filtered timer input passes through a synchroniser. A two-bit polarity code then picks which transitions count as events and whether the level is inverted. On each selected event the stage latches the free-running counter value, if the channel's enable bit allows capture. In output mode the same enable bit and the main polarity bit shape the compare-match request into the level on the pin.

A 16-bit control register holds the enable and polarity bits of both channels. Other timer functions can use the conditioned level and the one-cycle edge strobe of each channel. Examples are triggering, gating and the slave modes, which all sit outside this stage.

Top module: `ccx_polarity_stage`

## Requirements
- R1: After reset the control register reads 0x0000, both pins are low, no capture flag is raised, both capture values are 0 and no edge strobe is active.
- R2: A register write takes effect at the next clock edge. Channel 0 uses bit 0 as enable, bit 1 as polarity and bit 3 as complementary polarity. Channel 1 uses bits 4, 5 and 7 for the same roles. All other bits (2, 6, 15:8) read back as 0 whatever was written.
- R3: Suppose the channel input is stable at clock edge k. Then the edge strobe is high for exactly one cycle, between edges k+1 and k+2. The conditioned level takes the new value at edge k+1.
- R4: Code {comp-polarity, polarity} = 00 reacts to rising edges only and passes the level non-inverted.
- R5: Code 01 reacts to falling edges only and presents the inverted level.
- R6: Code 11 reacts to both rising and falling edges and passes the level non-inverted.
- R7: The reserved code 10 behaves exactly like code 00.
- R8: In input mode with the enable bit at 1, a strobe raises the capture flag for one cycle, at edge k+2. At that same edge the capture value takes the counter value sampled there. With the enable bit at 0 no flag is raised and the capture value is unchanged.
- R9: In output mode no capture happens, whatever the input does.
- R10: In output mode with the enable bit at 1, the pin shows the compare request one clock later. The pin is active high when the polarity bit is 0 and active low when it is 1.
- R11: When the enable bit is 0, or the channel is in input mode, the pin is held at the inactive level, which equals the polarity bit. The complementary polarity bit has no effect on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 16 | Control register write data |
| cfg_rdata_o | output | 16 | Control register contents |
| cnt_i | input | 16 | Timer counter value |
| tin_i | input | 2 | Filtered timer input per channel |
| mode_out_i | input | 2 | Per channel: 1 = output mode, 0 = input mode |
| cmp_req_i | input | 2 | Compare-match request per channel |
| lvl_o | output | 2 | Conditioned input level per channel |
| edge_o | output | 2 | Selected-edge strobe per channel |
| cap_vld_o | output | 2 | One-cycle capture flag per channel |
| cap_val_o | output | 32 | Captured counter values, channel 0 in bits 15:0 |
| pin_o | output | 2 | Conditioned output pin level per channel |

## Verification
Take an input transition set up before clock edge k. Its conditioned level and edge strobe are due in the cycle after edge k+1. The strobe must be gone again after edge k+2, which is also the edge at which the capture flag and value appear. The bench changes inputs just after the falling edge and samples 2 ns after each rising edge, counting those edges explicitly. At the moment of stimulus the driver task records the counter value that will be presented at edge k+2 and queues it, and the monitor compares it against the flag in that exact cycle. Pin results are checked one rising edge after the compare request or register write that caused them.

// File: rtl/ccx_pkg.sv
package ccx_pkg;

   typedef enum logic [1:0] {
      EDG_RISE = 2'd0,
      EDG_FALL = 2'd1,
      EDG_BOTH = 2'd2
   } edge_sel_e;

   typedef struct packed {
      logic np;   // complementary polarity
      logic p;    // polarity
      logic en;   // capture / output enable
   } ch_cfg_t;

   // {np,p}: 00 rise, 01 fall, 11 both, 10 (reserved) falls back to rise
   function automatic edge_sel_e decode_code(input logic np, input logic p);
      case ({np, p})
         2'b01:   decode_code = EDG_FALL;
         2'b11:   decode_code = EDG_BOTH;
         default: decode_code = EDG_RISE;
      endcase
   endfunction

endpackage

// File: rtl/ccx_cfg_reg.sv
module ccx_cfg_reg #(
   parameter int REG_W = 16,
   parameter int NCH   = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we_i,
   input  logic [REG_W-1:0]              wdata_i,
   output logic [REG_W-1:0]              rdata_o,
   output ccx_pkg::ch_cfg_t [NCH-1:0]    cfg_o
);

   localparam int FIELD_W = 4;

   function automatic logic [REG_W-1:0] build_mask();
      logic [REG_W-1:0] m;
      m = '0;
      for (int c = 0; c < NCH; c++) begin
         m[FIELD_W*c]     = 1'b1;
         m[FIELD_W*c + 1] = 1'b1;
         m[FIELD_W*c + 3] = 1'b1;
      end
      return m;
   endfunction

   localparam logic [REG_W-1:0] WR_MASK = build_mask();

   initial begin : elab_chk
      assert (FIELD_W*NCH <= REG_W) else $fatal(1, "ccx_cfg_reg: register too narrow for channels");
   end

   logic [REG_W-1:0] reg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) reg_q <= '0;
      else if (we_i) reg_q <= wdata_i & WR_MASK;
   end

   assign rdata_o = reg_q;

   for (genvar c = 0; c < NCH; c++) begin : g_fld
      assign cfg_o[c].en = reg_q[FIELD_W*c];
      assign cfg_o[c].p  = reg_q[FIELD_W*c + 1];
      assign cfg_o[c].np = reg_q[FIELD_W*c + 3];
   end

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_o & ~WR_MASK) == '0); // R2

endmodule

// File: rtl/ccx_in_cond.sv
module ccx_in_cond #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tin_i,
   input  logic [CNT_W-1:0]    cnt_i,
   input  ccx_pkg::ch_cfg_t    cfg_i,
   input  logic                is_out_i,
   output logic                lvl_o,
   output logic                edge_o,
   output logic                cap_vld_o,
   output logic [CNT_W-1:0]    cap_val_o
);
   import ccx_pkg::*;

   initial begin : elab_chk
      assert (SYNC_STAGES >= 2) else $fatal(1, "ccx_in_cond: need at least two sync stages");
      assert (CNT_W >= 1) else $fatal(1, "ccx_in_cond: bad counter width");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   cur;
   logic                   rise, fall;
   edge_sel_e              sel;
   logic                   cap_vld_q;
   logic [CNT_W-1:0]       cap_val_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], tin_i};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign cur  = sync_q[SYNC_STAGES-1];
   assign rise = cur & ~prev_q;
   assign fall = ~cur & prev_q;
   assign sel  = decode_code(cfg_i.np, cfg_i.p);

   always_comb begin
      case (sel)
         EDG_RISE: edge_o = rise;
         EDG_FALL: edge_o = fall;
         default:  edge_o = rise | fall;
      endcase
   end

   assign lvl_o = cur ^ (sel == EDG_FALL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_vld_q <= 1'b0;
         cap_val_q <= '0;
      end else begin
         cap_vld_q <= edge_o & cfg_i.en & ~is_out_i;
         if (edge_o & cfg_i.en & ~is_out_i) cap_val_q <= cnt_i;
      end
   end

   assign cap_vld_o = cap_vld_q;
   assign cap_val_o = cap_val_q;

   AST_EDGE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_o && sel != EDG_BOTH) |-> lvl_o); // R5
   AST_CAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_vld_o |-> (cap_val_o == $past(cnt_i))); // R8
   AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_vld_o |-> $stable(cap_val_o)); // R8
   AST_NO_CAP_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(is_out_i) |-> !cap_vld_o); // R9

endmodule

// File: rtl/ccx_out_cond.sv
module ccx_out_cond #(
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_i,
   input  ccx_pkg::ch_cfg_t cfg_i,
   input  logic             is_out_i,
   output logic             pin_o
);

   logic drive;

   // inactive level equals the polarity bit; np never reaches the pin
   assign drive = (is_out_i & cfg_i.en) ? (cmp_i ^ cfg_i.p) : cfg_i.p;

   if (OUT_REG) begin : g_reg
      logic pin_q;
      always_ff @(posedge clk) begin
         if (!rst_n) pin_q <= 1'b0;
         else        pin_q <= drive;
      end
      assign pin_o = pin_q;

      AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         $past(!(is_out_i && cfg_i.en)) |-> (pin_o == $past(cfg_i.p))); // R11
      AST_PIN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
         $past(is_out_i && cfg_i.en) |-> (pin_o == ($past(cmp_i) ^ $past(cfg_i.p)))); // R10
   end else begin : g_comb
      assign pin_o = drive;
   end

endmodule

// File: rtl/ccx_polarity_stage.sv
module ccx_polarity_stage #(
   parameter int CNT_W       = 16,
   parameter int REG_W       = 16,
   parameter int NCH         = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we_i,
   input  logic [REG_W-1:0]      cfg_wdata_i,
   output logic [REG_W-1:0]      cfg_rdata_o,
   input  logic [CNT_W-1:0]      cnt_i,
   input  logic [NCH-1:0]        tin_i,
   input  logic [NCH-1:0]        mode_out_i,
   input  logic [NCH-1:0]        cmp_req_i,
   output logic [NCH-1:0]        lvl_o,
   output logic [NCH-1:0]        edge_o,
   output logic [NCH-1:0]        cap_vld_o,
   output logic [NCH*CNT_W-1:0]  cap_val_o,
   output logic [NCH-1:0]        pin_o
);

   initial begin : elab_chk
      assert (NCH >= 1) else $fatal(1, "ccx_polarity_stage: need a channel");
   end

   ccx_pkg::ch_cfg_t [NCH-1:0] cfg;

   ccx_cfg_reg #(.REG_W(REG_W), .NCH(NCH)) cfg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (cfg_we_i),
      .wdata_i (cfg_wdata_i),
      .rdata_o (cfg_rdata_o),
      .cfg_o   (cfg)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      ccx_in_cond #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) in_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .tin_i     (tin_i[c]),
         .cnt_i     (cnt_i),
         .cfg_i     (cfg[c]),
         .is_out_i  (mode_out_i[c]),
         .lvl_o     (lvl_o[c]),
         .edge_o    (edge_o[c]),
         .cap_vld_o (cap_vld_o[c]),
         .cap_val_o (cap_val_o[c*CNT_W +: CNT_W])
      );

      ccx_out_cond #(.OUT_REG(OUT_REG)) out_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .cmp_i    (cmp_req_i[c]),
         .cfg_i    (cfg[c]),
         .is_out_i (mode_out_i[c]),
         .pin_o    (pin_o[c])
      );
   end

endmodule

// File: tb/ccx_polarity_stage_tb_top.sv
module ccx_polarity_stage_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic [15:0] cnt_q = '0;
   logic [1:0]  tin = '0;
   logic [1:0]  mode_out = '0;
   logic [1:0]  cmp = '0;
   logic [1:0]  lvl, edg, cap_vld, pin;
   logic [31:0] cap_val;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;
   logic [15:0] cfg_shadow = '0;
   logic [15:0] last_cap [2];
   logic [15:0] q0 [$];
   logic [15:0] q1 [$];

   always #5 clk = ~clk;
   always @(negedge clk) cnt_q <= cnt_q + 16'd1;

   ccx_polarity_stage dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
      .cfg_rdata_o(cfg_rdata), .cnt_i(cnt_q), .tin_i(tin), .mode_out_i(mode_out),
      .cmp_req_i(cmp), .lvl_o(lvl), .edge_o(edg), .cap_vld_o(cap_vld),
      .cap_val_o(cap_val), .pin_o(pin)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // monitor: pop expected captures as they appear
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         for (int c = 0; c < 2; c++) begin
            if (cap_vld[c]) begin
               if ((c == 0 ? q0.size() : q1.size()) == 0) begin
                  check("R8 unexpected capture", 32'd1, 32'd0);
               end else begin
                  logic [15:0] e;
                  e = (c == 0) ? q0.pop_front() : q1.pop_front();
                  check("R8 capture value", cap_val[c*16 +: 16], e);
                  last_cap[c] = e;
               end
            end
         end
      end
   end

   task automatic wr_cfg(input logic [15:0] v);
      @(negedge clk); #1;
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk); #1;
      cfg_we = 1'b0;
      cfg_shadow = v & 16'h00BB;
   endtask

   // drive channel input; expect strobe/level per mode
   task automatic drive_in(input int ch, input logic v, input logic exp_edge,
                           input logic exp_lvl, input string tag);
      @(negedge clk); #1;
      tin[ch] = v;
      if (exp_edge && cfg_shadow[4*ch] && !mode_out[ch]) begin
         if (ch == 0) q0.push_back(cnt_q + 16'd2);
         else         q1.push_back(cnt_q + 16'd2);
      end
      @(posedge clk); @(posedge clk); #2;
      check({tag, " edge strobe"}, {31'd0, edg[ch]}, {31'd0, exp_edge});
      check({tag, " level"}, {31'd0, lvl[ch]}, {31'd0, exp_lvl});
      @(posedge clk); #2;
      check("R3 strobe one cycle", {31'd0, edg[ch]}, 32'd0);
      repeat (2) @(posedge clk);
   endtask

   task automatic drive_cmp(input int ch, input logic v, input logic exp_pin, input string tag);
      @(negedge clk); #1;
      cmp[ch] = v;
      @(posedge clk); #2;
      check(tag, {31'd0, pin[ch]}, {31'd0, exp_pin});
   endtask

   initial begin : watchdog
      #2000000;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin : stim
      last_cap[0] = '0; last_cap[1] = '0;
      repeat (3) @(posedge clk);
      #2;
      check("R1 reg reset", cfg_rdata, 32'h0);
      check("R1 pins reset", pin, 2'b00);
      check("R1 capture flag reset", cap_vld, 2'b00);
      check("R1 capture value reset", cap_val, 32'h0);
      check("R1 strobe reset", edg, 2'b00);
      @(negedge clk); rst_n = 1'b1;

      // R2 register layout and reserved bits
      wr_cfg(16'hFFFF); check("R2 reserved read zero", cfg_rdata, 32'h00BB);
      wr_cfg(16'h0000); check("R2 clear", cfg_rdata, 32'h0);

      // R4 code 00 on both channels, capture enabled
      wr_cfg(16'h0011);
      drive_in(0, 1'b1, 1'b1, 1'b1, "R4 rise ch0");
      drive_in(0, 1'b0, 1'b0, 1'b0, "R4 fall ignored ch0");
      drive_in(1, 1'b1, 1'b1, 1'b1, "R4 rise ch1");
      drive_in(1, 1'b0, 1'b0, 1'b0, "R4 fall ignored ch1");

      // R5 code 01 on ch0
      wr_cfg(16'h0013);
      drive_in(0, 1'b1, 1'b0, 1'b0, "R5 rise ignored");
      drive_in(0, 1'b0, 1'b1, 1'b1, "R5 fall inverted");

      // R6 code 11 on ch0, also ch1 polarity bit 5 -> falling
      wr_cfg(16'h003B);
      drive_in(0, 1'b1, 1'b1, 1'b1, "R6 rise");
      drive_in(0, 1'b0, 1'b1, 1'b0, "R6 fall");
      drive_in(1, 1'b1, 1'b0, 1'b0, "R2 ch1 polarity bit5 rise");
      drive_in(1, 1'b0, 1'b1, 1'b1, "R2 ch1 polarity bit5 fall");

      // R7 reserved code 10 acts as 00
      wr_cfg(16'h0019);
      drive_in(0, 1'b1, 1'b1, 1'b1, "R7 rise");
      drive_in(0, 1'b0, 1'b0, 1'b0, "R7 fall ignored");

      // R8 capture disabled keeps value
      wr_cfg(16'h0010);
      drive_in(0, 1'b1, 1'b1, 1'b1, "R8 disabled strobe");
      check("R8 value held when disabled", cap_val[15:0], last_cap[0]);
      drive_in(0, 1'b0, 1'b0, 1'b0, "R8 disabled fall");

      // R9 output mode: no capture
      mode_out = 2'b01;
      wr_cfg(16'h0011);
      drive_in(0, 1'b1, 1'b1, 1'b1, "R9 out-mode strobe");
      check("R9 value held in output mode", cap_val[15:0], last_cap[0]);
      drive_in(0, 1'b0, 1'b0, 1'b0, "R9 out-mode fall");

      // R10 output polarity
      drive_cmp(0, 1'b1, 1'b1, "R10 active high on");
      drive_cmp(0, 1'b0, 1'b0, "R10 active high off");
      wr_cfg(16'h0013);
      drive_cmp(0, 1'b1, 1'b0, "R10 active low on");
      drive_cmp(0, 1'b0, 1'b1, "R10 active low off");

      // R11 disabled output -> inactive level; np ignored
      wr_cfg(16'h0012);
      drive_cmp(0, 1'b1, 1'b1, "R11 disabled low-active idle");
      wr_cfg(16'h0010);
      drive_cmp(0, 1'b1, 1'b0, "R11 disabled high-active idle");
      wr_cfg(16'h0019);
      drive_cmp(0, 1'b1, 1'b1, "R11 np ignored on");
      drive_cmp(0, 1'b0, 1'b0, "R11 np ignored off");

      // ch1 output with bits 4/5: active low
      mode_out = 2'b11;
      wr_cfg(16'h0030);
      drive_cmp(1, 1'b1, 1'b0, "R2 ch1 output bit5 active low");
      drive_cmp(1, 1'b0, 1'b1, "R2 ch1 output idle");
      mode_out = 2'b00;
      @(negedge clk); #1;
      @(posedge clk); #2;
      check("R11 input mode pin at polarity", pin, 2'b10);

      repeat (4) @(posedge clk);
      #3;
      check("R8 all captures seen", q0.size() + q1.size(), 32'd0);
      finish_run();
   end

endmodule